// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit picks one bit out of a register operand, reports that bit's value in a carry flag, and can return the operand with that bit cleared or inverted. The operand can be 16, 32 or 64 bits wide. The unit also has a masked AND test. That test raises a zero flag when the operand and a mask share no set bit within the selected width, and it leaves the operand unchanged.

A request is presented with `req_valid` high and is captured on that clock edge. The results appear on the registered outputs in the following cycle and hold until the next accepted request. A byte-sized request is refused. The unit raises a one-cycle error pulse for it and changes no operand or flag output.

Top module: `bit_test_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_data`, `flag_c`, `flag_z` and `err_pulse` are all 0 after that edge.
- R2: For a legal bit operation (`op_sel` 0, 1 or 2), `flag_c` after the capturing edge equals the value of the selected operand bit before any change.
- R3: Test only (`op_sel`=0) returns `res_data` equal to the operand input.
- R4: Test and clear (`op_sel`=1) returns the operand with the selected bit forced to 0. Repeating it on the result gives carry 0 and the same value.
- R5: Test and invert (`op_sel`=2) returns the operand with the selected bit inverted. Applying it twice restores the original value.
- R6: The bit index is taken modulo the width. `width_sel`=1 (16-bit) uses index bits [3:0], `width_sel`=2 (32-bit) uses [4:0], and `width_sel`=3 (64-bit) uses [5:0]. Operand bits above the selected bit are passed through unchanged.
- R7: Masked test (`op_sel`=3) sets `flag_z` to 1 exactly when (operand AND mask) is zero within the low 16/32/64 bits of the selected width. It returns the operand unchanged and leaves `flag_c` unchanged.
- R8: A valid request with `width_sel`=0 (byte) sets `err_pulse` high for exactly the next cycle and leaves `res_data`, `flag_c` and `flag_z` unchanged. A legal request leaves `err_pulse` low.
- R9: When `req_valid` is low at an edge, `res_data`, `flag_c` and `flag_z` hold their values and `err_pulse` is low.
- R10: The bit operations (`op_sel` 0 to 2) leave `flag_z` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, captured on the rising edge |
| op_sel | input | 2 | 0 test, 1 test+clear, 2 test+invert, 3 masked AND test |
| width_sel | input | 2 | 0 byte (illegal), 1 16-bit, 2 32-bit, 3 64-bit |
| bit_idx | input | 6 | Bit index, reduced modulo the width |
| opnd | input | 64 | Register operand |
| tmask | input | 64 | Mask for the masked AND test |
| res_data | output | 64 | Written-back operand |
| flag_c | output | 1 | Carry: the old value of the selected bit |
| flag_z | output | 1 | Zero flag from the masked test |
| err_pulse | output | 1 | One-cycle pulse for a byte-sized request |

## Verification
The bench applies each bit operation twice to the same bit. This exposes a design that samples carry after the change instead of before it: such a design would report 0 where the clear found a 1, and a flipped value on an invert. It also sends indexes above the selected width. A design that skips the modulo step would touch a high bit and leave the intended low bit alone. The masked test uses a hit above bit 15 while the 16-bit width is selected, so a design that does not apply the width would report non-zero. Byte requests and idle cycles come right after flag-setting operations, so a design that writes anything on those cycles shows a changed result or flag.

// File: rtl/bit_test_unit.sv
module bit_test_unit #(
  parameter int DW = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    op_sel,
  input  logic [1:0]    width_sel,
  input  logic [IW-1:0] bit_idx,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] tmask,
  output logic [DW-1:0] res_data,
  output logic          flag_c,
  output logic          flag_z,
  output logic          err_pulse
);
  localparam logic [1:0] OP_TEST = 2'd0;
  localparam logic [1:0] OP_CLR  = 2'd1;
  localparam logic [1:0] OP_INV  = 2'd2;
  localparam logic [1:0] OP_AND  = 2'd3;

  logic [IW-1:0] idx_eff;
  logic [DW-1:0] wmask;
  logic [DW-1:0] bit_oh;
  logic [DW-1:0] next_data;
  logic          old_bit;
  logic          and_zero;
  logic          illegal;

  assign illegal = (width_sel == 2'd0);

  always_comb begin
    idx_eff = '0;
    wmask   = '0;
    case (width_sel)
      2'd1: begin
        idx_eff = {2'b00, bit_idx[3:0]};
        wmask   = {{(DW-16){1'b0}}, {16{1'b1}}};
      end
      2'd2: begin
        idx_eff = {1'b0, bit_idx[4:0]};
        wmask   = {{(DW-32){1'b0}}, {32{1'b1}}};
      end
      2'd3: begin
        idx_eff = bit_idx;
        wmask   = '1;
      end
      default: ;
    endcase
  end

  assign bit_oh   = {{(DW-1){1'b0}}, 1'b1} << idx_eff;
  assign old_bit  = |(opnd & bit_oh);
  assign and_zero = ~|(opnd & tmask & wmask);

  always_comb begin
    case (op_sel)
      OP_CLR:  next_data = opnd & ~bit_oh;
      OP_INV:  next_data = opnd ^ bit_oh;
      default: next_data = opnd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= req_valid & illegal;
      if (req_valid && !illegal) begin
        res_data <= next_data;
        if (op_sel == OP_AND) flag_z <= and_zero;
        else                  flag_c <= old_bit;
      end
    end
  end

  logic unused_test;
  assign unused_test = (op_sel == OP_TEST);
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk #(
  parameter int DW = 64,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    op_sel,
  input logic [1:0]    width_sel,
  input logic [IW-1:0] bit_idx,
  input logic [DW-1:0] opnd,
  input logic [DW-1:0] tmask,
  input logic [DW-1:0] res_data,
  input logic          flag_c,
  input logic          flag_z,
  input logic          err_pulse
);
  a_r8_err_holds: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ($stable(res_data) && $stable(flag_c) && $stable(flag_z)));

  a_r8_err_raised: assert property (@(posedge clk) disable iff (rst)
    (req_valid && width_sel == 2'd0) |=> err_pulse);

  a_r8_no_err_legal: assert property (@(posedge clk) disable iff (rst)
    (req_valid && width_sel != 2'd0) |=> !err_pulse);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(res_data) && $stable(flag_c) && $stable(flag_z) && !err_pulse));

  a_r3_test_keeps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_sel == 2'd0 && width_sel != 2'd0) |=> (res_data == $past(opnd)));

  a_r7_and_keeps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_sel == 2'd3 && width_sel != 2'd0) |=> (res_data == $past(opnd) && $stable(flag_c)));

  a_r10_zero_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_sel != 2'd3 && width_sel != 2'd0) |=> $stable(flag_z));
endmodule

bind bit_test_unit bit_test_unit_chk #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/sim_bit_test_unit.sv
module sim_bit_test_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [1:0]  width_sel = '0;
  logic [5:0]  bit_idx = '0;
  logic [63:0] opnd = '0;
  logic [63:0] tmask = '0;
  logic [63:0] res_data;
  logic        flag_c, flag_z, err_pulse;

  logic [63:0] e_res = '0;
  logic        e_c = 0, e_z = 0, e_err = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bit_test_unit u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .op_sel(op_sel),
    .width_sel(width_sel), .bit_idx(bit_idx), .opnd(opnd), .tmask(tmask),
    .res_data(res_data), .flag_c(flag_c), .flag_z(flag_z), .err_pulse(err_pulse));

  task automatic compare(string tag);
    checks++;
    if (res_data !== e_res || flag_c !== e_c || flag_z !== e_z || err_pulse !== e_err) begin
      failures++;
      $display("FAIL %s: got res=%h c=%b z=%b err=%b, expected res=%h c=%b z=%b err=%b",
               tag, res_data, flag_c, flag_z, err_pulse, e_res, e_c, e_z, e_err);
    end
  endtask

  task automatic model();
    int w, k;
    bit any;
    if (rst) begin
      e_res = '0; e_c = 0; e_z = 0; e_err = 0;
      return;
    end
    e_err = req_valid && width_sel == 0;
    if (!req_valid || width_sel == 0) return;
    w = (width_sel == 1) ? 16 : (width_sel == 2) ? 32 : 64;
    k = int'(bit_idx) % w;
    if (op_sel == 3) begin
      any = 0;
      for (int i = 0; i < w; i++) if (opnd[i] && tmask[i]) any = 1;
      e_z = !any;
      e_res = opnd;
    end else begin
      e_c = opnd[k];
      e_res = opnd;
      if (op_sel == 1) e_res[k] = 1'b0;
      if (op_sel == 2) e_res[k] = ~opnd[k];
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [1:0] ws, logic [5:0] idx,
                      logic [63:0] d, logic [63:0] m, string tag);
    req_valid = v; op_sel = op; width_sel = ws; bit_idx = idx; opnd = d; tmask = m;
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 1, 0, 0, 0, "R1 reset");
    step(1, 2, 3, 5, 64'hFFFF, 0, "R1 reset with request");
    rst = 1'b0;
    for (int b = 0; b < 8; b++) step(1, 0, 1, 6'(b), 64'h5A, 0, "R2 R3 test 0x5A");
    step(1, 1, 1, 1, 64'h5A, 0, "R4 clear bit1");
    step(1, 1, 1, 1, 64'h58, 0, "R4 clear again");
    step(1, 2, 2, 0, 64'h5A, 0, "R5 invert bit0");
    step(1, 2, 2, 0, 64'h5B, 0, "R5 invert back");
    step(1, 2, 1, 6'd17, 64'hFFFF_0000_0000_0000, 0, "R6 16-bit wrap");
    step(1, 1, 2, 6'd37, 64'h0000_0020_0000_0020, 0, "R6 32-bit wrap");
    step(1, 2, 3, 6'd63, 64'h0, 0, "R6 64-bit top bit");
    step(1, 3, 1, 0, 64'hF0, 64'h00, "R7 and zero");
    step(1, 0, 3, 3, 64'h8, 0, "R10 zero kept");
    step(1, 3, 1, 0, 64'hF0, 64'h18, "R7 and nonzero");
    step(1, 3, 1, 0, 64'h1_0000, 64'h1_0000, "R7 width applied");
    step(1, 3, 2, 0, 64'h1_0000, 64'h1_0000, "R7 32-bit hit");
    step(1, 2, 0, 3, 64'hAAAA, 0, "R8 byte rejected");
    step(1, 3, 0, 0, 64'h0, 64'h0, "R8 byte and rejected");
    step(0, 0, 1, 0, 64'h1234, 0, "R8 pulse ends");
    step(0, 1, 3, 2, 64'hFFFF, 0, "R9 idle");
    step(0, 3, 3, 0, 64'h0, 64'h0, "R9 idle and");
    step(1, 1, 3, 6'd40, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4 R2 64-bit clear");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule